// File: doc/BRIEF.md
# Multiprocessor Reservation Monitor

This block keeps one address reservation per processor for load-locked / store-conditional atomic sequences. A locked load writes the processor's reservation slot with the granule of its physical address and arms the slot. A later store-conditional from the same processor is tested against that slot and answered with a result code. Every store that actually reaches memory, whether plain or a conditional one that is allowed to proceed, disarms every slot, including the issuer's own, that holds the same 16-byte granule.

Requests arrive on a single port, one per cycle, tagged with the processor number, address, kind and an uncacheable flag. Store-conditionals are answered one cycle later with a code and a flag telling the memory side whether the store may be performed. Per processor, the block also counts consecutive failed store-conditionals and emits a one-cycle warning, tagged with the processor number, each time that run reaches a multiple of a configurable period.

Top module: `resv_monitor`

## Requirements
- R1: A request of kind 1 (locked load) records the granule of `req_addr` in the issuing processor's slot and arms it; a following cacheable store-conditional from that processor to the same granule returns code 1 with `rsp_stored` high.
- R2: Granule matching ignores address bits [3:0]: addresses that differ only in those bits match, addresses that differ in bit 4 or above do not.
- R3: A cacheable store-conditional (kind 3, `req_uncached` low) returns code 1 if the issuer's slot was armed and code 0 otherwise; `rsp_stored` is high only when the slot was armed and its granule matches the request.
- R4: A failing cacheable store-conditional disarms the issuer's slot, leaves the slots of all other processors unchanged, and gives `rsp_stored` low.
- R5: An uncacheable store-conditional returns code 2 with `rsp_stored` high, clears the issuer's failure run, and disarms matching slots like any store.
- R6: A plain store (kind 2) or a proceeding store-conditional disarms every slot, the issuer's included, whose granule matches; slots holding other granules stay armed.
- R7: Each failing cacheable store-conditional adds one to the issuer's failure run; a proceeding one resets the run to zero.
- R8: When a processor's failure run reaches a multiple of `WARN_PERIOD`, `warn_valid` pulses for one cycle with `warn_cpu` equal to that processor, in the same cycle as the failing response.
- R9: A store-conditional is answered with `rsp_valid` high exactly one cycle after it is presented; plain loads (kind 0), locked loads and plain stores produce no response.
- R10: Reset disarms all slots, clears all failure runs and drives `rsp_valid` and `warn_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_cpu | input | CPU_W | Issuing processor number |
| req_addr | input | ADDR_W | Physical address |
| req_kind | input | 2 | 0 load, 1 locked load, 2 store, 3 store-conditional |
| req_uncached | input | 1 | Request targets uncacheable space |
| rsp_valid | output | 1 | Store-conditional answer valid |
| rsp_code | output | 2 | 0 fail, 1 reservation held, 2 uncacheable |
| rsp_stored | output | 1 | Store may be performed |
| warn_valid | output | 1 | Failure-run warning pulse |
| warn_cpu | output | CPU_W | Processor the warning refers to |

## Verification
The bench builds the monitor with four processors, a 40-bit address and `WARN_PERIOD` lowered to 5. The short period brings the warning wrap, its repetition and the counter resets by successful and uncacheable conditionals within a few dozen requests, while the four slots allow cross-processor clearing, non-matching survivors and the failing-conditional isolation to be seen through later store-conditional answers.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    KIND_LOAD   = 2'd0,
    KIND_LOCKED = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_COND   = 2'd3
  } req_kind_e;

  localparam logic [1:0] CODE_FAIL    = 2'd0;
  localparam logic [1:0] CODE_HELD    = 2'd1;
  localparam logic [1:0] CODE_UNCACHE = 2'd2;
endpackage

// File: rtl/resv_slot.sv
module resv_slot #(
  parameter int GRAN_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              drop_own,
  input  logic              snoop_en,
  input  logic [GRAN_W-1:0] req_gran,
  output logic              armed,
  output logic              match
);
  logic [GRAN_W-1:0] held_gran;

  assign match = (held_gran == req_gran);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      held_gran <= '0;
    end else if (set_en) begin
      armed     <= 1'b1;
      held_gran <= req_gran;
    end else if (drop_own || (snoop_en && match)) begin
      armed <= 1'b0;
    end
  end

  // R1: a locked load arms the slot with its granule
  p_lock_set_r1: assert property (@(posedge clk) disable iff (rst)
    set_en |=> (armed && held_gran == $past(req_gran)));
  // R6: a matching proceeding store disarms the slot
  p_snoop_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (snoop_en && match && !set_en) |=> !armed);
  // R4: a failing conditional disarms its own slot
  p_own_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (drop_own && !set_en) |=> !armed);
endmodule

// File: rtl/resv_fail_ctr.sv
module resv_fail_ctr #(
  parameter int WARN_PERIOD = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic fail_inc,
  input  logic run_clear,
  output logic wrap
);
  localparam int CNT_W = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WARN_PERIOD - 1);

  logic [CNT_W-1:0] cnt;

  assign wrap = fail_inc && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || run_clear) cnt <= '0;
    else if (fail_inc)    cnt <= wrap ? '0 : cnt + 1'b1;
  end

  // R7: the run position never leaves its period
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R7: a proceeding conditional restarts the run
  p_run_clear_r7: assert property (@(posedge clk) disable iff (rst)
    run_clear |=> (cnt == '0));
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int NUM_CPU     = 4,
  parameter int ADDR_W      = 40,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 100000,
  localparam int CPU_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic              req_uncached,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic              rsp_stored,
  output logic              warn_valid,
  output logic [CPU_W-1:0]  warn_cpu
);
  localparam int GRAN_W = ADDR_W - GRAN_BITS;

  logic [GRAN_W-1:0]  req_gran;
  logic               unused_low_bits;
  logic [NUM_CPU-1:0] sel, armed, match, wrap;
  logic               is_locked, is_store, is_cond;
  logic               own_armed, own_match, own_wrap;
  logic               cond_ok, cond_fail, proceed;

  assign req_gran        = req_addr[ADDR_W-1:GRAN_BITS];
  assign unused_low_bits = ^req_addr[GRAN_BITS-1:0];

  assign is_locked = req_valid && (req_kind == KIND_LOCKED);
  assign is_store  = req_valid && (req_kind == KIND_STORE);
  assign is_cond   = req_valid && (req_kind == KIND_COND);

  assign own_armed = |(sel & armed);
  assign own_match = |(sel & match);
  assign own_wrap  = |(sel & wrap);

  assign cond_ok   = is_cond && (req_uncached || (own_armed && own_match));
  assign cond_fail = is_cond && !cond_ok;
  assign proceed   = is_store || cond_ok;

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    assign sel[i] = req_valid && (req_cpu == CPU_W'(i));

    resv_slot #(.GRAN_W(GRAN_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .set_en   (is_locked && sel[i]),
      .drop_own (cond_fail && sel[i]),
      .snoop_en (proceed),
      .req_gran (req_gran),
      .armed    (armed[i]),
      .match    (match[i])
    );

    resv_fail_ctr #(.WARN_PERIOD(WARN_PERIOD)) u_ctr (
      .clk       (clk),
      .rst       (rst),
      .fail_inc  (cond_fail && sel[i]),
      .run_clear (cond_ok && sel[i]),
      .wrap      (wrap[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_code   <= CODE_FAIL;
      rsp_stored <= 1'b0;
      warn_valid <= 1'b0;
      warn_cpu   <= '0;
    end else begin
      rsp_valid  <= is_cond;
      rsp_code   <= req_uncached ? CODE_UNCACHE : (own_armed ? CODE_HELD : CODE_FAIL);
      rsp_stored <= cond_ok;
      warn_valid <= own_wrap;
      warn_cpu   <= req_cpu;
    end
  end

  // R9: answers only follow a store-conditional one cycle earlier
  p_rsp_timing_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_kind == KIND_COND));
  // R3: no answer carries the unused code 3
  p_code_legal_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_code != 2'd3));
  // R5: uncacheable conditionals always proceed with code 2
  p_uncache_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_uncached)) |-> (rsp_code == CODE_UNCACHE && rsp_stored));
  // R8: a warning only accompanies a failed cacheable conditional
  p_warn_src_r8: assert property (@(posedge clk) disable iff (rst)
    warn_valid |-> (rsp_valid && !rsp_stored && warn_cpu == $past(req_cpu)));
  // R3: a stored conditional reported the slot as held or uncacheable
  p_stored_code_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_stored) |-> (rsp_code != CODE_FAIL));
endmodule

// File: tb/resv_monitor_test.sv
module resv_monitor_test;
  localparam int NCPU = 4;
  localparam int AW   = 40;
  localparam int CW   = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [CW-1:0] req_cpu = '0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_kind = 2'd0;
  logic          req_uncached = 1'b0;
  logic          rsp_valid, rsp_stored, warn_valid;
  logic [1:0]    rsp_code;
  logic [CW-1:0] warn_cpu;

  int checks = 0;
  int failures = 0;

  localparam logic [AW-1:0] A = 40'h12_3456_7800;
  localparam logic [AW-1:0] B = 40'h00_0000_4440;

  always #5 clk = ~clk;

  resv_monitor #(.NUM_CPU(NCPU), .ADDR_W(AW), .GRAN_BITS(4), .WARN_PERIOD(5)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cpu(req_cpu),
    .req_addr(req_addr), .req_kind(req_kind), .req_uncached(req_uncached),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_stored(rsp_stored),
    .warn_valid(warn_valid), .warn_cpu(warn_cpu)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // drive one request for one cycle, sample just after the capturing edge
  task automatic send(int cpu, logic [AW-1:0] addr, logic [1:0] kind, logic unc);
    @(negedge clk);
    req_valid = 1'b1; req_cpu = CW'(cpu); req_addr = addr;
    req_kind = kind; req_uncached = unc;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic cond(string tag, int cpu, logic [AW-1:0] addr, logic unc,
                      logic [1:0] code, logic stored, logic warn);
    send(cpu, addr, 2'd3, unc);
    chk({tag, " valid"}, rsp_valid, 1'b1);
    chk({tag, " code"}, rsp_code, code);
    chk({tag, " stored"}, rsp_stored, stored);
    chk({tag, " warn"}, warn_valid, warn);
    if (warn) chk({tag, " warn_cpu"}, warn_cpu, cpu);
  endtask

  task automatic t_reset();
    do_reset();
    send(0, A, 2'd1, 1'b0);
    do_reset();
    chk("R10 rsp_valid after reset", rsp_valid, 1'b0);
    chk("R10 warn_valid after reset", warn_valid, 1'b0);
    cond("R10 slot cleared", 0, A, 1'b0, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_basic();
    do_reset();
    send(1, A, 2'd0, 1'b0);
    chk("R9 plain load no response", rsp_valid, 1'b0);
    send(1, A, 2'd1, 1'b0);
    chk("R9 locked load no response", rsp_valid, 1'b0);
    cond("R1 lock then conditional", 1, A, 1'b0, 2'd1, 1'b1, 1'b0);
    @(posedge clk); #1;
    chk("R9 response lasts one cycle", rsp_valid, 1'b0);
    send(1, B, 2'd2, 1'b0);
    chk("R9 plain store no response", rsp_valid, 1'b0);
  endtask

  task automatic t_granule();
    do_reset();
    send(2, A, 2'd1, 1'b0);
    cond("R2 low bits ignored", 2, A + 40'hF, 1'b0, 2'd1, 1'b1, 1'b0);
    send(2, A, 2'd1, 1'b0);
    cond("R3 other granule held flag", 2, A + 40'h10, 1'b0, 2'd1, 1'b0, 1'b0);
    cond("R4 flag dropped after fail", 2, A, 1'b0, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_cross();
    do_reset();
    send(1, A, 2'd1, 1'b0);
    cond("R4 other cpu fails", 0, A, 1'b0, 2'd0, 1'b0, 1'b0);
    cond("R4 owner unaffected", 1, A, 1'b0, 2'd1, 1'b1, 1'b0);
  endtask

  task automatic t_clear_all();
    do_reset();
    send(0, A, 2'd1, 1'b0);
    send(1, A, 2'd1, 1'b0);
    send(3, B, 2'd1, 1'b0);
    send(2, A + 40'h8, 2'd2, 1'b0);
    cond("R6 store clears cpu0", 0, A, 1'b0, 2'd0, 1'b0, 1'b0);
    cond("R6 store clears cpu1", 1, A, 1'b0, 2'd0, 1'b0, 1'b0);
    cond("R6 other granule survives", 3, B, 1'b0, 2'd1, 1'b1, 1'b0);
    send(0, A, 2'd1, 1'b0);
    cond("R6 own conditional ok", 0, A, 1'b0, 2'd1, 1'b1, 1'b0);
    cond("R6 own store clears self", 0, A, 1'b0, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_uncached();
    do_reset();
    send(1, A, 2'd1, 1'b0);
    cond("R5 uncached code", 2, A, 1'b1, 2'd2, 1'b1, 1'b0);
    cond("R5 uncached clears match", 1, A, 1'b0, 2'd0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) cond("R5 pre fail", 2, B, 1'b0, 2'd0, 1'b0, 1'b0);
    cond("R5 uncached resets run", 2, B, 1'b1, 2'd2, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) cond("R5 post fail", 2, B, 1'b0, 2'd0, 1'b0, 1'b0);
    cond("R5 warn after full run", 2, B, 1'b0, 2'd0, 1'b0, 1'b1);
  endtask

  task automatic t_warn();
    do_reset();
    for (int k = 0; k < 4; k++) cond("R7 early fail", 3, A, 1'b0, 2'd0, 1'b0, 1'b0);
    send(3, A, 2'd1, 1'b0);
    cond("R7 success resets run", 3, A, 1'b0, 2'd1, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) cond("R7 restarted run", 3, A, 1'b0, 2'd0, 1'b0, 1'b0);
    cond("R8 first warning", 3, A, 1'b0, 2'd0, 1'b0, 1'b1);
    for (int k = 0; k < 4; k++) cond("R8 between warnings", 3, A, 1'b0, 2'd0, 1'b0, 1'b0);
    cond("R8 second warning", 3, A, 1'b0, 2'd0, 1'b0, 1'b1);
    @(posedge clk); #1;
    chk("R8 pulse one cycle", warn_valid, 1'b0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_granule();
    t_cross();
    t_clear_all();
    t_uncached();
    t_warn();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule